// File: doc/BRIEF.md
# Keyed watchdog timer with mode lock

This block is a watchdog counter for a system bus. It advances on one of two synchronous, single-cycle tick inputs: a slow tick from a low-speed source, or a main tick derived from the main clock. Software restarts the count by writing a fixed key byte to the key register. The mode register sets the clock source and the overflow period. Software may write it only once after reset. A counter overflow raises a one-cycle reset request. So do illegal bus accesses: a wrong key, a second mode write, a malformed mode byte, or a single-bit write.

One clock-source code stops the watchdog completely. While stopped, the counter does not advance and none of the illegal-access conditions raise the reset request. A halt input pauses counting without clearing the counter, and counting resumes from the held value when halt is released. The block does not reset itself from its own request: distributing the request as a system reset is left to the surrounding logic.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the period field is 3'b111 and the clock-source field is 2'b00, so with no writes the first reset request comes after 2^(BASE_LOG+7) slow ticks.
- R2: With period field n (bits [2:0] of the mode byte), the reset request is a single-cycle pulse in the cycle after the 2^(BASE_LOG+n)-th tick since the last clear, and the count then restarts from zero.
- R3: A byte write of 8'hAC with addr_sel=1 (key register) clears the counter to zero.
- R4: A byte write of any other value to the key register raises the reset request in the next cycle.
- R5: A pulse on bit_wr, to either address, raises the reset request in the next cycle and changes neither register nor the counter.
- R6: Only the first byte write with addr_sel=0 (mode register) after reset is accepted. Each later mode write raises the reset request in the next cycle and leaves the mode fields unchanged.
- R7: Every byte write to the mode register clears the counter.
- R8: A mode write whose bits [7:5] are not 3'b011 raises the reset request, leaves the fields unchanged and still uses up the single allowed write.
- R9: Mode bits [4:3] select the tick: 2'b00 and 2'b01 select slow_tick, 2'b10 selects main_tick, and 2'b11 stops counting so that no overflow occurs.
- R10: While the clock-source field is 2'b11, wrong keys, bit writes and repeated or malformed mode writes raise no reset request.
- R11: While halt is high, ticks are ignored and the counter holds its value. Counting resumes from that value when halt falls.
- R12: A clearing write in the same cycle as the terminal tick clears the counter, and no overflow request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Single-cycle tick from the slow source |
| main_tick | input | 1 | Single-cycle tick from the main-clock divider |
| halt | input | 1 | Pauses counting while high |
| wr_en | input | 1 | Byte write strobe |
| bit_wr | input | 1 | Single-bit write strobe (always illegal) |
| addr_sel | input | 1 | 0 selects the mode register, 1 the key register |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle reset request |

## Verification
Some behaviours are checked by assertions on every cycle. The counter never passes the terminal count of the selected period. The mode fields never change once the lock is set. A stopped watchdog never emits a request. A correct key, a halt or a bit write has its expected effect one cycle later. Other behaviours can only be shown by the bench scenarios. These include the exact overflow cycle for each period and clock source, a clearing write that meets the terminal tick, and a malformed first write that uses up the lock. For these, a behavioural model runs alongside the design and is compared with rst_req on every clock.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int         BASE_LOG = 11,
  parameter logic [7:0] KEY      = 8'hAC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       main_tick,
  input  logic       halt,
  input  logic       wr_en,
  input  logic       bit_wr,
  input  logic       addr_sel,
  input  logic [7:0] wr_data,
  output logic       rst_req
);
  localparam int CW = BASE_LOG + 7;

  logic [2:0]    cyc_q;
  logic [1:0]    cks_q;
  logic          lock_q;
  logic [CW-1:0] cnt_q;
  logic          rst_req_q;

  wire stopped   = (cks_q == 2'b11);
  wire mode_wr   = wr_en & ~bit_wr & ~addr_sel;
  wire key_wr    = wr_en & ~bit_wr & addr_sel;
  wire prefix_ok = (wr_data[7:5] == 3'b011);
  wire key_ok    = (wr_data == KEY);
  wire fault     = ~stopped & (bit_wr | (mode_wr & (lock_q | ~prefix_ok)) | (key_wr & ~key_ok));
  wire clr       = mode_wr | (key_wr & key_ok);
  wire tick      = ~halt & ~stopped & (cks_q[1] ? main_tick : slow_tick);

  wire [CW-1:0] term = {CW{1'b1}} >> (3'd7 - cyc_q);
  wire at_term = (cnt_q == term);
  wire ovf     = tick & at_term & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_term ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= 3'b111;
      cks_q  <= 2'b00;
      lock_q <= 1'b0;
    end else if (mode_wr && !lock_q) begin
      lock_q <= 1'b1;
      if (prefix_ok) begin
        cks_q <= wr_data[4:3];
        cyc_q <= wr_data[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= fault | ovf;
  end

  assign rst_req = rst_req_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= term); // R2
  AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bit_wr && addr_sel && wr_data == KEY) |=> (cnt_q == '0)); // R3
  AST_BITWR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !stopped) |=> rst_req); // R5
  AST_RELOCK_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bit_wr && !addr_sel && lock_q && !stopped) |=> rst_req); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable({cyc_q, cks_q})); // R6
  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |=> !rst_req); // R10
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable(cnt_q)); // R11
endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
  localparam int B = 2;

  logic clk = 0, rst_n = 0;
  logic slow_tick = 0, main_tick = 0, halt = 0;
  logic wr_en = 0, bit_wr = 0, addr_sel = 0;
  logic [7:0] wr_data = 0;
  logic rst_req;

  keyed_wdt #(.BASE_LOG(B)) i_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .main_tick(main_tick),
    .halt(halt), .wr_en(wr_en), .bit_wr(bit_wr), .addr_sel(addr_sel),
    .wr_data(wr_data), .rst_req(rst_req)
  );

  always #2 clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  int tick_mode = 0;
  bit halt_rand = 0;

  int m_cyc, m_cks, m_lock, m_cnt;
  bit exp_req = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cyc = 7; m_cks = 0; m_lock = 0; m_cnt = 0; exp_req = 0;
    end else begin
      bit stp, flt, clr, tk, ov;
      int per;
      stp = (m_cks == 3);
      per = (1 << (B + m_cyc)) - 1;
      tk  = !halt && !stp && ((m_cks == 2) ? main_tick : slow_tick);
      flt = 0; clr = 0; ov = 0;
      if (bit_wr) flt = !stp;
      else if (wr_en) begin
        if (!addr_sel) begin
          clr = 1;
          if (m_lock) flt = !stp;
          else begin
            m_lock = 1;
            if (wr_data[7:5] == 3'b011) begin
              m_cks = wr_data[4:3]; m_cyc = wr_data[2:0];
            end else flt = !stp;
          end
        end else if (wr_data == 8'hAC) clr = 1;
        else flt = !stp;
      end
      if (clr) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == per) begin ov = 1; m_cnt = 0; end
        else m_cnt++;
      end
      exp_req = flt || ov;
    end
  end

  always @(negedge clk) begin
    cycles++;
    vectors++;
    if (rst_req !== exp_req) begin
      errors++;
      $display("FAIL %s cycle %0d: rst_req=%b expected %b", cur_req, cycles, rst_req, exp_req);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cyc(input bit we, input bit bw, input bit a, input logic [7:0] d);
    @(negedge clk);
    wr_en = we; bit_wr = bw; addr_sel = a; wr_data = d;
    case (tick_mode)
      0: begin slow_tick = 1; main_tick = 0; end
      1: begin slow_tick = (cycles % 3 == 0); main_tick = 0; end
      2: begin slow_tick = $urandom_range(0, 1); main_tick = $urandom_range(0, 1); end
      default: begin slow_tick = 0; main_tick = 0; end
    endcase
    halt = halt_rand ? $urandom_range(0, 1) : 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 8'h00);
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    cyc(1, 0, a, d);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    idle(2);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    cur_req = "R1"; idle(600);
    cur_req = "R3"; idle(200); wr(1, 8'hAC); idle(400); wr(1, 8'hAC); idle(600);
    cur_req = "R4"; wr(1, 8'h55); idle(5); wr(1, 8'hAD); idle(5);
    cur_req = "R5"; cyc(0, 1, 1, 8'hAC); idle(3); cyc(0, 1, 0, 8'h61); idle(3);
    cur_req = "R7"; tick_mode = 1; idle(37); wr(0, 8'h61);
    cur_req = "R2"; idle(100);
    cur_req = "R6"; wr(0, 8'h67); idle(100);

    do_reset; tick_mode = 0;
    cur_req = "R8"; idle(20); wr(0, 8'h07); idle(10);
    cur_req = "R6"; wr(0, 8'h60); idle(600);

    do_reset; tick_mode = 2;
    cur_req = "R9"; wr(0, 8'h70); idle(200);
    do_reset; wr(0, 8'h6A); idle(200);
    do_reset; tick_mode = 0; wr(0, 8'h78); idle(600);
    cur_req = "R10"; wr(1, 8'h00); cyc(0, 1, 1, 8'h00); wr(0, 8'h61); wr(0, 8'h00); idle(20);

    do_reset; tick_mode = 0;
    cur_req = "R11"; wr(0, 8'h63); halt_rand = 1; idle(400); halt_rand = 0; idle(50);

    do_reset;
    cur_req = "R12"; wr(0, 8'h60);
    for (int k = 0; k < 8; k++) begin idle(k); wr(1, 8'hAC); end
    idle(20);

    cur_req = "R2";
    for (int r = 0; r < 5; r++) begin
      do_reset; tick_mode = 2; halt_rand = (r % 2 == 1);
      for (int i = 0; i < 1000; i++) begin
        int p = $urandom_range(0, 199);
        if (p < 4) wr(1, 8'hAC);
        else if (p == 4) wr(1, 8'($urandom));
        else if (p == 5) wr(0, {3'b011, 5'($urandom)});
        else if (p == 6) cyc(0, 1, 1'($urandom), 8'h00);
        else idle(1);
      end
    end
    halt_rand = 0;
    idle(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule